// File: doc/BRIEF.md
# Transceiver Control Register Bank with Set/Clear Aliases

This block is the byte-wide register file that sits behind the serial transport of a USB transceiver's control interface. Software reaches it through a flat address/data port. Each control register answers at three consecutive addresses:

- a plain write address that replaces the whole byte;
- a set alias that ORs a mask into the register;
- a clear alias that removes the bits of a mask.

With the aliases, a driver can change one field without a read-modify-write over the slow link.

The bank also watches five link-detect inputs: ID pin grounded, session end, session valid, VBUS valid and host disconnect. It samples them into a live status register. Every transition of an input is checked against per-bit rising-edge and falling-edge enables. An enabled edge sets a sticky latch bit, and the OR of the latch drives one registered interrupt line.

The operating-mode and transceiver-select fields of the function control register are decoded for the neighbouring PHY logic. A small group of registers high in the map have no aliases and are written only directly.

Top module: `xcvr_regbank`

## Requirements
- R1: A write to the base address of an aliased register replaces its whole value. The base addresses are 0x04 (function control), 0x07 (interface control), 0x0A (OTG control), 0x0D (rising-edge enable) and 0x10 (falling-edge enable).
- R2: A write of a mask to base+1 sets the mask's 1 bits and leaves all other bits unchanged.
- R3: A write of a mask to base+2 clears the mask's 1 bits and leaves all other bits unchanged.
- R4: A read at base+1 or base+2 returns the current value of the register at base.
- R5: After reset, the function control register reads 0x40 (suspend bit 6 set). Every other register and the irq output read 0.
- R6: Address 0x13 returns the link inputs as sampled at the previous clock edge. The bit positions are: ID ground bit 4, session end bit 3, session valid bit 2, VBUS valid bit 1, host disconnect bit 0. Writes to 0x13 have no effect.
- R7: A latch bit at 0x14 becomes 1 when its input rises while the matching rising-edge enable bit is 1. It also becomes 1 when its input falls while the matching falling-edge enable bit is 1. An edge whose enable bit is 0 leaves the latch bit unchanged.
- R8: A latch bit stays 1 until a write to 0x14 carries a 1 in that bit position. Bits written 0 are kept. A level that stays high after the clear does not set the bit again.
- R9: irq equals the OR of the latch bits as they were one clock earlier.
- R10: The registers at 0xC0 and 0xC1 have no aliases. A direct write replaces their value. A write to 0xC2 changes nothing.
- R11: An unmapped address (for example 0x15 or 0xC2) reads as 0.
- R12: op_mode shows function control bits 4:3 (0 normal, 1 non-driving, 2 bit-stuff/NRZI disabled). xcvr_sel shows bits 1:0 (0 HS, 1 FS, 2 LS, 3 FS-for-LS).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the current address |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data or mask |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| link_in | input | 5 | Link-detect inputs, bit 4 down to 0 as listed in R6 |
| op_mode | output | 2 | Decoded operating-mode field |
| xcvr_sel | output | 2 | Decoded transceiver-select field |
| irq | output | 1 | Registered OR of the interrupt latch |

## Verification
Each alias is tried with masks that overlap the stored value only in part. A set that cleared bits, or a clear that set them, therefore changes the readback, as does an alias that fell through to a plain write.

The link inputs are driven through the following patterns, each of which exposes a different fault in the edge logic:
- both edges of one bit, with only one direction enabled;
- two bits rising together when only one is enabled;
- a level held high across a latch clear.

Unaliased, unmapped and read-only addresses are written with non-zero data and read back, to show that the write touched nothing.

// File: rtl/xrb_pkg.sv
package xrb_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_DIRECT = 2'd1,
    ACC_SET    = 2'd2,
    ACC_CLR    = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    OPM_NORMAL   = 2'd0,
    OPM_NONDRIVE = 2'd1,
    OPM_RAWLINE  = 2'd2,
    OPM_RESERVED = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    XSEL_HS    = 2'd0,
    XSEL_FS    = 2'd1,
    XSEL_LS    = 2'd2,
    XSEL_FS_LS = 2'd3
  } xcvr_sel_e;

  // Which of the three addresses of a register, if any, addr hits.
  function automatic acc_kind_e alias_kind(input logic [ADDR_W-1:0] addr,
                                           input logic [ADDR_W-1:0] base);
    acc_kind_e k;
    if (addr == base)                           k = ACC_DIRECT;
    else if (addr == base + ADDR_W'(1))         k = ACC_SET;
    else if (addr == base + ADDR_W'(2))         k = ACC_CLR;
    else                                        k = ACC_NONE;
    return k;
  endfunction

  // Next value of an aliased register for one write.
  function automatic logic [DATA_W-1:0] apply_alias(input logic [DATA_W-1:0] cur,
                                                    input acc_kind_e      kind,
                                                    input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] nv;
    case (kind)
      ACC_DIRECT: nv = mask;
      ACC_SET:    nv = cur | mask;
      ACC_CLR:    nv = cur & ~mask;
      default:    nv = cur;
    endcase
    return nv;
  endfunction

  // Latch update: write-one-to-clear first, then new hits are ORed in.
  function automatic logic [DATA_W-1:0] latch_next(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] clr,
                                                   input logic [DATA_W-1:0] hits);
    return (cur & ~clr) | hits;
  endfunction

endpackage

// File: rtl/xrb_alias_reg.sv
module xrb_alias_reg
  import xrb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE    = 8'h04,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter bit                ALIASED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_hit,
  output logic [DATA_W-1:0] q
);

  acc_kind_e kind_raw;
  acc_kind_e kind;
  logic      wr_hit;

  assign kind_raw = alias_kind(addr, BASE);

  generate
    if (ALIASED) begin : g_alias
      assign kind = kind_raw;
    end else begin : g_plain
      assign kind = (kind_raw == ACC_DIRECT) ? ACC_DIRECT : ACC_NONE;
    end
  endgenerate

  assign rd_hit = (kind != ACC_NONE);
  assign wr_hit = we && (kind != ACC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (wr_hit) q <= apply_alias(q, kind, wdata);
  end

  // R1
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == ACC_DIRECT) |=> (q == $past(wdata)));

  // R2
  set_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == ACC_SET) |=> ((q & $past(q)) == $past(q)));

  // R3
  clr_adds_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == ACC_CLR) |=> ((q | $past(q)) == $past(q)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));

endmodule

// File: rtl/xrb_irq_unit.sv
module xrb_irq_unit
  import xrb_pkg::*;
#(
  parameter int NSTAT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] link_in,
  input  logic [NSTAT-1:0] rise_en,
  input  logic [NSTAT-1:0] fall_en,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_mask,
  output logic [NSTAT-1:0] status,
  output logic [NSTAT-1:0] latch,
  output logic             irq
);

  logic [NSTAT-1:0] prev_q;
  logic [NSTAT-1:0] rise_hit;
  logic [NSTAT-1:0] fall_hit;
  logic [NSTAT-1:0] clr_eff;
  logic [DATA_W-1:0] latch_w;

  assign rise_hit = status & ~prev_q & rise_en;
  assign fall_hit = ~status & prev_q & fall_en;
  assign clr_eff  = clr_we ? clr_mask : '0;
  assign latch_w  = latch_next(DATA_W'(latch), DATA_W'(clr_eff),
                               DATA_W'(rise_hit | fall_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      prev_q <= '0;
      latch  <= '0;
      irq    <= 1'b0;
    end else begin
      status <= link_in;
      prev_q <= status;
      latch  <= latch_w[NSTAT-1:0];
      irq    <= |latch;
    end
  end

  // R6
  status_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status == $past(link_in)));

  // R7
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_hit) |=> ((latch & $past(rise_hit)) == $past(rise_hit)));

  // R7
  fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_hit) |=> ((latch & $past(fall_hit)) == $past(fall_hit)));

  // R8
  sticky_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((latch & $past(latch)) == $past(latch)));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|latch)));

endmodule

// File: rtl/xcvr_regbank.sv
module xcvr_regbank
  import xrb_pkg::*;
#(
  parameter int                NSTAT       = 5,
  parameter logic [ADDR_W-1:0] FUNC_BASE   = 8'h04,
  parameter logic [ADDR_W-1:0] IFC_BASE    = 8'h07,
  parameter logic [ADDR_W-1:0] OTG_BASE    = 8'h0A,
  parameter logic [ADDR_W-1:0] RISE_BASE   = 8'h0D,
  parameter logic [ADDR_W-1:0] FALL_BASE   = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h13,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 8'h14,
  parameter logic [ADDR_W-1:0] PLAIN_BASE  = 8'hC0,
  parameter int                NUM_PLAIN   = 2,
  parameter logic [DATA_W-1:0] FUNC_RST    = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSTAT-1:0]  link_in,
  output logic [1:0]        op_mode,
  output logic [1:0]        xcvr_sel,
  output logic              irq
);

  localparam int NUM_ALIASED = 5;
  localparam int IDX_FUNC    = 0;
  localparam int IDX_RISE    = 3;
  localparam int IDX_FALL    = 4;
  localparam logic [ADDR_W-1:0] ALIAS_BASES [NUM_ALIASED] =
    '{FUNC_BASE, IFC_BASE, OTG_BASE, RISE_BASE, FALL_BASE};

  logic [DATA_W-1:0] areg_q   [NUM_ALIASED];
  logic [NUM_ALIASED-1:0] areg_hit;
  logic [DATA_W-1:0] preg_q   [NUM_PLAIN];
  logic [NUM_PLAIN-1:0]   preg_hit;

  logic [NSTAT-1:0] status;
  logic [NSTAT-1:0] latch;
  logic             latch_clr_we;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ALIASED; gi++) begin : g_areg
      xrb_alias_reg #(
        .BASE    (ALIAS_BASES[gi]),
        .RST_VAL ((gi == IDX_FUNC) ? FUNC_RST : '0),
        .ALIASED (1'b1)
      ) i_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rd_hit (areg_hit[gi]),
        .q      (areg_q[gi])
      );
    end
    for (gi = 0; gi < NUM_PLAIN; gi++) begin : g_preg
      xrb_alias_reg #(
        .BASE    (PLAIN_BASE + ADDR_W'(gi)),
        .RST_VAL ('0),
        .ALIASED (1'b0)
      ) i_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rd_hit (preg_hit[gi]),
        .q      (preg_q[gi])
      );
    end
  endgenerate

  assign latch_clr_we = reg_we && (reg_addr == LATCH_ADDR);

  xrb_irq_unit #(.NSTAT(NSTAT)) i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_in  (link_in),
    .rise_en  (areg_q[IDX_RISE][NSTAT-1:0]),
    .fall_en  (areg_q[IDX_FALL][NSTAT-1:0]),
    .clr_we   (latch_clr_we),
    .clr_mask (reg_wdata[NSTAT-1:0]),
    .status   (status),
    .latch    (latch),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_ALIASED; i++)
      if (areg_hit[i]) reg_rdata = areg_q[i];
    for (int j = 0; j < NUM_PLAIN; j++)
      if (preg_hit[j]) reg_rdata = preg_q[j];
    if (reg_addr == STAT_ADDR)  reg_rdata = DATA_W'(status);
    if (reg_addr == LATCH_ADDR) reg_rdata = DATA_W'(latch);
  end

  assign op_mode  = areg_q[IDX_FUNC][4:3];
  assign xcvr_sel = areg_q[IDX_FUNC][1:0];

  // R4
  alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == FUNC_BASE + ADDR_W'(2)) |-> (reg_rdata == areg_q[IDX_FUNC]));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (areg_hit == '0 && preg_hit == '0 && reg_addr != STAT_ADDR &&
     reg_addr != LATCH_ADDR) |-> (reg_rdata == '0));

  // R8
  irq_only_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(latch != '0));

endmodule

// File: tb/test_xcvr_regbank.sv
module test_xcvr_regbank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] link_in = '0;
  logic [1:0] op_mode;
  logic [1:0] xcvr_sel;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  xcvr_regbank i_xcvr_regbank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_in(link_in),
    .op_mode(op_mode), .xcvr_sel(xcvr_sel), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read 0x%02h", a), reg_rdata, exp);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R5", 8'h04, 8'h40);
    rd_chk("R5", 8'h07, 8'h00);
    rd_chk("R5", 8'h0A, 8'h00);
    rd_chk("R5", 8'h0D, 8'h00);
    rd_chk("R5", 8'h10, 8'h00);
    rd_chk("R5", 8'h14, 8'h00);
    rd_chk("R5", 8'hC0, 8'h00);
    chk("R5", "irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_direct;
    wr(8'h07, 8'hA5);
    rd_chk("R1", 8'h07, 8'hA5);
    wr(8'h07, 8'h5A);
    rd_chk("R1", 8'h07, 8'h5A);
  endtask

  task automatic t_set_clr;
    wr(8'h0A, 8'h21);
    wr(8'h0B, 8'h06);
    rd_chk("R2", 8'h0A, 8'h27);
    rd_chk("R4", 8'h0B, 8'h27);
    rd_chk("R4", 8'h0C, 8'h27);
    wr(8'h0C, 8'h05);
    rd_chk("R3", 8'h0A, 8'h22);
    wr(8'h06, 8'h40);
    rd_chk("R3", 8'h04, 8'h00);
    rd_chk("R1", 8'h07, 8'h5A);
  endtask

  task automatic t_modes;
    wr(8'h04, 8'h12);
    chk("R12", "op_mode", {6'd0, op_mode}, 8'h02);
    chk("R12", "xcvr_sel", {6'd0, xcvr_sel}, 8'h02);
    wr(8'h05, 8'h01);
    chk("R12", "xcvr_sel after set", {6'd0, xcvr_sel}, 8'h03);
    wr(8'h06, 8'h10);
    chk("R12", "op_mode after clear", {6'd0, op_mode}, 8'h00);
    wr(8'h05, 8'h08);
    chk("R12", "op_mode non-driving", {6'd0, op_mode}, 8'h01);
  endtask

  task automatic t_status;
    @(negedge clk);
    link_in = 5'b10101;
    cyc(1);
    rd_chk("R6", 8'h13, 8'h15);
    wr(8'h13, 8'hFF);
    rd_chk("R6", 8'h13, 8'h15);
    link_in = 5'b10000;
    cyc(1);
    rd_chk("R6 id ground bit4", 8'h13, 8'h10);
    link_in = 5'b00000;
    cyc(3);
    wr(8'h14, 8'hFF);
    cyc(2);
  endtask

  task automatic t_latch;
    wr(8'h0D, 8'h02);
    link_in = 5'b00011;
    cyc(3);
    rd_chk("R7 rise enabled only", 8'h14, 8'h02);
    wr(8'h11, 8'h01);
    link_in = 5'b00010;
    cyc(3);
    rd_chk("R7 fall", 8'h14, 8'h03);
    link_in = 5'b00000;
    cyc(3);
    rd_chk("R7 disabled fall", 8'h14, 8'h03);
    wr(8'h14, 8'h02);
    rd_chk("R8 partial clear", 8'h14, 8'h01);
    link_in = 5'b00010;
    cyc(3);
    wr(8'h14, 8'h03);
    cyc(2);
    rd_chk("R8 level held", 8'h14, 8'h00);
    link_in = 5'b00000;
    wr(8'h0F, 8'h02);
    wr(8'h12, 8'h01);
    cyc(3);
  endtask

  task automatic t_irq;
    chk("R9", "irq idle", {7'd0, irq}, 8'h00);
    wr(8'h0E, 8'h04);
    link_in = 5'b00100;
    cyc(2);
    rd_chk("R7 session valid", 8'h14, 8'h04);
    chk("R9", "irq one cycle after latch", {7'd0, irq}, 8'h00);
    cyc(1);
    chk("R9", "irq set", {7'd0, irq}, 8'h01);
    wr(8'h14, 8'h04);
    chk("R9", "irq still high", {7'd0, irq}, 8'h01);
    cyc(1);
    chk("R9", "irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_plain;
    wr(8'hC0, 8'h3C);
    rd_chk("R10", 8'hC0, 8'h3C);
    wr(8'hC1, 8'h81);
    wr(8'hC2, 8'h77);
    rd_chk("R10", 8'hC1, 8'h81);
    rd_chk("R11", 8'hC2, 8'h00);
    rd_chk("R10", 8'hC0, 8'h3C);
    rd_chk("R11", 8'h15, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_direct;
    t_set_clr;
    t_modes;
    t_status;
    t_latch;
    t_irq;
    t_plain;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule